// File: doc/BRIEF.md
# Page-Write Load Controller

This block is the write-side sequencer of a byte-wide nonvolatile memory emulator built around a small on-chip array. The host issues byte writes by raising a one-cycle strobe together with an address and a data byte. The first accepted write opens a load window and fixes the page for that window. Further bytes of the same page may follow in any order. Each one is staged in a page buffer, and a per-byte mask records which offsets were loaded.

The window stays open while each new byte arrives within a configurable gap of the previous accepted byte. When that gap runs out, the block stops taking data and runs a self-timed programming period of fixed length. During that period it copies only the marked bytes into the array, one offset per cycle. A busy flag covers the whole span from the first byte of a window to the end of programming. The address and data of the most recent accepted write are presented at the ports. Writes that carry a foreign page address, and writes that arrive while programming is under way, are dropped and recorded in a sticky error flag. A registered read port lets the host inspect the array.

Top module: `page_load_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `wr_err`, `last_addr` and `last_data` are all zero.
- R2: The low `OFFS_W` (default 6) bits of an address select one of 64 bytes in a page, and the remaining upper bits select the page.
- R3: When the block is idle, a strobe is accepted and opens a load window. `busy` reads 1 from the cycle after that strobe's clock edge.
- R4: Within a window, a byte for the locked page is accepted if its strobe comes no later than `LOAD_TMO` cycles after the previous accepted strobe. An accepted byte restarts the gap count, and a byte that lands exactly on the expiry cycle is still accepted.
- R5: If `LOAD_TMO` cycles pass with no accepted byte, the window closes and programming begins. A strobe `LOAD_TMO+1` cycles after the last accepted byte is rejected, and its data never reaches the array.
- R6: A strobe in an open window whose page differs from the locked page is ignored. It sets `wr_err`, leaves `last_addr`/`last_data` unchanged, does not extend the window, and writes nothing.
- R7: Bytes of a window may be loaded in any offset order. An offset loaded more than once commits its latest value.
- R8: Only the offsets loaded in a window are written to the array. All other bytes of that page keep their previous contents.
- R9: `busy` drops to 0 exactly `LOAD_TMO + PROG_CYC` cycles after the edge of the last accepted strobe. `PROG_CYC` is raised to at least 64 if set lower. After that, a new window may open.
- R10: A strobe while programming is under way is ignored and sets `wr_err`.
- R11: `last_addr` and `last_data` take the address and data of each accepted strobe on its clock edge, and change at no other time.
- R12: `wr_err` stays set until reset, even across later accepted writes.
- R13: `rd_data` presents the array byte at `rd_addr` one clock after `rd_addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-cycle byte write strobe |
| wr_addr | input | ADDR_W | Write address: page in the upper bits, byte offset in the low OFFS_W bits |
| wr_data | input | DATA_W | Write data byte |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array byte at rd_addr, registered |
| busy | output | 1 | High from the first byte of a window until programming completes |
| wr_err | output | 1 | Sticky flag for dropped writes |
| last_addr | output | ADDR_W | Address of the last accepted write |
| last_data | output | DATA_W | Data of the last accepted write |

## Verification
The gap timer's expiry and the arrival of a new byte can land on the same clock edge. In that case the byte must win and keep the window open. The bench provokes this by placing a strobe exactly `LOAD_TMO` cycles after the previous accepted one, and then a second strobe one cycle beyond the limit. It judges the outcome by `wr_err` and `last_addr` right after each strobe, by the exact cycle in which `busy` falls, and by reading back the array, where only the on-time byte has landed.

// File: rtl/plc_pkg.sv
// Shared types for the page-write load controller.
package plc_pkg;

    // Sequencer phases: waiting for a first byte, gathering a page, committing it.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } plc_state_e;

endpackage

// File: rtl/plc_window_fsm.sv
// Load-window sequencer.
// Decides per strobe whether the byte is accepted or rejected, locks the page
// on the first byte, times the inter-byte gap and then the programming period.
// Assumes LOAD_TMO >= 1 and PROG_LEN >= 1; the strobe is a single-cycle pulse.
module plc_window_fsm
    import plc_pkg::*;
#(
    parameter int PAGE_W   = 4,
    parameter int LOAD_TMO = 8,
    parameter int PROG_LEN = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [PAGE_W-1:0] page_in,
    output logic              accept,
    output logic              reject,
    output plc_state_e        state_o,
    output logic [$clog2(PROG_LEN+1)-1:0] prog_idx,
    output logic              prog_last,
    output logic [PAGE_W-1:0] page_o
);
    localparam int GAP_W  = $clog2(LOAD_TMO + 1);
    localparam int PCNT_W = $clog2(PROG_LEN + 1);

    plc_state_e         state_q;
    logic [GAP_W-1:0]   gap_q;
    logic [PCNT_W-1:0]  pcnt_q;
    logic [PAGE_W-1:0]  page_q;
    logic               gap_end;

    // Accept rule: any byte when idle, only same-page bytes while loading.
    always_comb begin
        accept = stb && ((state_q == ST_IDLE) ||
                         ((state_q == ST_LOAD) && (page_in == page_q)));
        reject = stb && !accept;
    end

    // Terminal counts of the gap timer and the program timer.
    always_comb begin
        gap_end   = (gap_q == GAP_W'(LOAD_TMO - 1));
        prog_last = (state_q == ST_PROG) && (pcnt_q == PCNT_W'(PROG_LEN - 1));
    end

    // Phase register, page lock and both timers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gap_q   <= '0;
            pcnt_q  <= '0;
            page_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_LOAD;
                        gap_q   <= '0;
                        page_q  <= page_in;
                    end
                end
                ST_LOAD: begin
                    if (accept) begin
                        gap_q <= '0;
                    end else if (gap_end) begin
                        state_q <= ST_PROG;
                        pcnt_q  <= '0;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (prog_last) begin
                        state_q <= ST_IDLE;
                        pcnt_q  <= '0;
                    end else begin
                        pcnt_q <= pcnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs for the datapath.
    always_comb begin
        state_o  = state_q;
        prog_idx = pcnt_q;
        page_o   = page_q;
    end
endmodule

// File: rtl/plc_page_buf.sv
// Page staging buffer.
// One data byte and one loaded-mark per page offset. A load writes the byte
// and sets its mark; a clear drops all marks at the end of programming.
// Assumes load and clear are never requested in the same cycle.
module plc_page_buf #(
    parameter int OFFS_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [OFFS_W-1:0] ld_offs,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              clr,
    input  logic [OFFS_W-1:0] sel_offs,
    output logic [DATA_W-1:0] sel_data,
    output logic              sel_mark
);
    localparam int PAGE_BYTES = 1 << OFFS_W;

    logic [DATA_W-1:0]     data_w [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mark_w;

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
        logic              m_q;
        logic [DATA_W-1:0] d_q;
        logic              hit;

        assign hit = ld_en && (ld_offs == OFFS_W'(i));

        // Loaded-mark of this offset: set on load, dropped on clear.
        always_ff @(posedge clk) begin
            if (!rst_n)   m_q <= 1'b0;
            else if (clr) m_q <= 1'b0;
            else if (hit) m_q <= 1'b1;
        end

        // Staged byte of this offset: latest load wins.
        always_ff @(posedge clk) begin
            if (!rst_n)   d_q <= '0;
            else if (hit) d_q <= ld_data;
        end

        assign mark_w[i] = m_q;
        assign data_w[i] = d_q;
    end

    // Selected slot for the commit walker.
    always_comb begin
        sel_data = data_w[sel_offs];
        sel_mark = mark_w[sel_offs];
    end
endmodule

// File: rtl/plc_array.sv
// Emulated storage array: one write port, one registered read port.
// Contents are not reset; only the read register is.
module plc_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;

    // Commit port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= mem[raddr];
    end

    assign rdata = rd_q;
endmodule

// File: rtl/page_load_ctrl.sv
// Page-write load controller (top).
// Gathers same-page bytes into a staging buffer during a gap-timed load
// window, then walks the page offsets during a fixed programming period and
// commits only marked bytes. Dropped writes set a sticky error flag.
// Assumes wr_stb is a single-cycle pulse per byte. PROG_CYC below the page
// size is raised to the page size so the walker reaches every offset.
module page_load_ctrl
    import plc_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 8,
    parameter int OFFS_W   = 6,
    parameter int LOAD_TMO = 37500,
    parameter int PROG_CYC = 2500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              wr_err,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_data
);
    localparam int PAGE_W     = ADDR_W - OFFS_W;
    localparam int PAGE_BYTES = 1 << OFFS_W;
    localparam int PROG_LEN   = (PROG_CYC < PAGE_BYTES) ? PAGE_BYTES : PROG_CYC;
    localparam int PCNT_W     = $clog2(PROG_LEN + 1);

    logic              accept;
    logic              reject;
    plc_state_e        state;
    logic [PCNT_W-1:0] prog_idx;
    logic              prog_last;
    logic [PAGE_W-1:0] lock_page;

    logic [OFFS_W-1:0] walk_offs;
    logic [DATA_W-1:0] walk_data;
    logic              walk_mark;
    logic              walk_in_page;
    logic              commit_we;

    logic              err_q;
    logic [ADDR_W-1:0] last_addr_q;
    logic [DATA_W-1:0] last_data_q;

    plc_window_fsm #(
        .PAGE_W  (PAGE_W),
        .LOAD_TMO(LOAD_TMO),
        .PROG_LEN(PROG_LEN)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (wr_stb),
        .page_in  (wr_addr[ADDR_W-1:OFFS_W]),
        .accept   (accept),
        .reject   (reject),
        .state_o  (state),
        .prog_idx (prog_idx),
        .prog_last(prog_last),
        .page_o   (lock_page)
    );

    plc_page_buf #(
        .OFFS_W(OFFS_W),
        .DATA_W(DATA_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (accept),
        .ld_offs (wr_addr[OFFS_W-1:0]),
        .ld_data (wr_data),
        .clr     (prog_last),
        .sel_offs(walk_offs),
        .sel_data(walk_data),
        .sel_mark(walk_mark)
    );

    // Commit walker: one offset per programming cycle, marked bytes only.
    always_comb begin
        walk_offs    = prog_idx[OFFS_W-1:0];
        walk_in_page = (32'(prog_idx) < PAGE_BYTES);
        commit_we    = (state == ST_PROG) && walk_in_page && walk_mark;
    end

    plc_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (commit_we),
        .waddr({lock_page, walk_offs}),
        .wdata(walk_data),
        .raddr(rd_addr),
        .rdata(rd_data)
    );

    // Record of the last accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_addr_q <= '0;
            last_data_q <= '0;
        end else if (accept) begin
            last_addr_q <= wr_addr;
            last_data_q <= wr_data;
        end
    end

    // Sticky error on any dropped write.
    always_ff @(posedge clk) begin
        if (!rst_n)      err_q <= 1'b0;
        else if (reject) err_q <= 1'b1;
    end

    // Port drive.
    always_comb begin
        busy      = (state != ST_IDLE);
        wr_err    = err_q;
        last_addr = last_addr_q;
        last_data = last_data_q;
    end
endmodule

// File: rtl/page_load_ctrl_chk.sv
// Port-level property checker for page_load_ctrl, attached by bind.
module page_load_ctrl_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int OFFS_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic              busy,
    input logic              wr_err,
    input logic [ADDR_W-1:0] last_addr,
    input logic [DATA_W-1:0] last_data
);
    // R3
    busy_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_stb));

    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err);

    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_err) |-> $past(wr_stb));

    // R11
    last_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(last_addr) || !$stable(last_data)) |-> $past(wr_stb));

    // R6
    page_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(last_addr))
            |-> (last_addr[ADDR_W-1:OFFS_W] == $past(last_addr[ADDR_W-1:OFFS_W])));
endmodule

bind page_load_ctrl page_load_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .OFFS_W(OFFS_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .busy     (busy),
    .wr_err   (wr_err),
    .last_addr(last_addr),
    .last_data(last_data)
);

// File: tb/page_load_ctrl_tb_top.sv
// Directed bench for page_load_ctrl: one task per scenario.
module page_load_ctrl_tb_top;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int T  = 8;
    localparam int P  = 80;
    localparam int PG2 = 2 * 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          busy;
    logic          wr_err;
    logic [AW-1:0] last_addr;
    logic [DW-1:0] last_data;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    page_load_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .OFFS_W(6), .LOAD_TMO(T), .PROG_CYC(P)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .wr_err(wr_err), .last_addr(last_addr), .last_data(last_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one strobe at the next posedge; returns at the following negedge.
    task automatic put_byte(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        rd_addr = a;
        @(negedge clk);
        d = rd_data;
    endtask

    function automatic logic [DW-1:0] fill_val(input int off);
        return DW'(off) ^ 8'h5A;
    endfunction

    task automatic t_reset_state();
        do_reset();
        check("R1 busy", 32'(busy), 0);
        check("R1 err", 32'(wr_err), 0);
        check("R1 last_addr", 32'(last_addr), 0);
        check("R1 last_data", 32'(last_data), 0);
    endtask

    task automatic t_single_byte();
        logic [DW-1:0] v;
        put_byte(AW'(3 * 64 + 5), 8'hA5);
        check("R3 busy after first byte", 32'(busy), 1);
        check("R11 last_addr", 32'(last_addr), 3 * 64 + 5);
        check("R11 last_data", 32'(last_data), 8'hA5);
        idle(T + P - 1);
        check("R9 busy one cycle before end", 32'(busy), 1);
        idle(1);
        check("R9 busy falls on time", 32'(busy), 0);
        rd(AW'(3 * 64 + 5), v);
        check("R13 R2 readback page3 off5", 32'(v), 8'hA5);
    endtask

    task automatic t_full_page();
        logic [DW-1:0] v;
        for (int off = 63; off >= 0; off--) begin
            put_byte(AW'(PG2 + off), fill_val(off));
            if (off == 63) check("R9 next window accepted", 32'(wr_err), 0);
        end
        idle(T + P);
        check("R9 full page done", 32'(busy), 0);
        for (int off = 0; off < 64; off++) begin
            rd(AW'(PG2 + off), v);
            check("R7 R2 descending full page", 32'(v), 32'(fill_val(off)));
        end
        put_byte(AW'(PG2 + 10), 8'h11);
        put_byte(AW'(PG2 + 3), 8'h22);
        put_byte(AW'(PG2 + 10), 8'h33);
        idle(T + P);
        rd(AW'(PG2 + 10), v);
        check("R7 reloaded offset keeps latest", 32'(v), 8'h33);
        rd(AW'(PG2 + 3), v);
        check("R8 loaded offset", 32'(v), 8'h22);
        rd(AW'(PG2 + 4), v);
        check("R8 unloaded offset unchanged", 32'(v), 32'(fill_val(4)));
        rd(AW'(PG2 + 11), v);
        check("R8 unloaded offset unchanged", 32'(v), 32'(fill_val(11)));
    endtask

    task automatic t_gap_edge();
        logic [DW-1:0] v;
        put_byte(AW'(PG2 + 0), 8'hC1);
        idle(T - 1);
        put_byte(AW'(PG2 + 1), 8'hC2);
        check("R4 byte on expiry cycle accepted", 32'(last_addr), PG2 + 1);
        check("R4 no error", 32'(wr_err), 0);
        idle(T);
        put_byte(AW'(PG2 + 2), 8'hC3);
        check("R5 late byte rejected", 32'(wr_err), 1);
        check("R5 last_addr kept", 32'(last_addr), PG2 + 1);
        idle(P - 2);
        check("R5 busy before end", 32'(busy), 1);
        idle(1);
        check("R5 busy falls on time", 32'(busy), 0);
        rd(AW'(PG2 + 1), v);
        check("R4 on-time byte committed", 32'(v), 8'hC2);
        rd(AW'(PG2 + 2), v);
        check("R5 late byte not committed", 32'(v), 32'(fill_val(2)));
    endtask

    task automatic t_wrong_page();
        logic [DW-1:0] v;
        do_reset();
        check("R12 err cleared by reset", 32'(wr_err), 0);
        put_byte(AW'(PG2 + 20), 8'h77);
        idle(2);
        put_byte(AW'(3 * 64 + 5), 8'h99);
        check("R6 foreign page flags error", 32'(wr_err), 1);
        check("R6 last_addr unchanged", 32'(last_addr), PG2 + 20);
        check("R6 last_data unchanged", 32'(last_data), 8'h77);
        idle(T + P - 4);
        check("R6 window not extended, still busy", 32'(busy), 1);
        idle(1);
        check("R6 window not extended, done", 32'(busy), 0);
        rd(AW'(PG2 + 20), v);
        check("R6 own page byte committed", 32'(v), 8'h77);
        rd(AW'(3 * 64 + 5), v);
        check("R6 foreign byte not written", 32'(v), 8'hA5);
        put_byte(AW'(PG2 + 21), 8'h44);
        check("R12 err stays after good write", 32'(wr_err), 1);
        check("R11 good write recorded", 32'(last_data), 8'h44);
        idle(T + P);
        rd(AW'(PG2 + 21), v);
        check("R8 byte after error committed", 32'(v), 8'h44);
    endtask

    task automatic t_during_prog();
        logic [DW-1:0] v;
        do_reset();
        put_byte(AW'(PG2 + 30), 8'hE1);
        idle(T);
        put_byte(AW'(PG2 + 31), 8'hEE);
        check("R10 write in programming flagged", 32'(wr_err), 1);
        check("R10 last_addr kept", 32'(last_addr), PG2 + 30);
        check("R10 still busy", 32'(busy), 1);
        idle(P - 1);
        check("R10 busy ends on time", 32'(busy), 0);
        rd(AW'(PG2 + 31), v);
        check("R10 dropped byte not written", 32'(v), 32'(fill_val(31)));
        rd(AW'(PG2 + 30), v);
        check("R10 window byte committed", 32'(v), 8'hE1);
    endtask

    initial begin
        t_reset_state();
        t_single_byte();
        t_full_page();
        t_gap_edge();
        t_wrong_page();
        t_during_prog();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule